// File: doc/BRIEF.md
# Dual-Section Registered Bus Transceiver

This block links two buses, A and B, through a pair of identical sections, each carrying a 9-bit slice. Each section has an active-low output enable and a direction control. Together these decide which port, if any, the section drives. Each section also holds two storage registers, one per direction. A select input for each direction chooses what the driven port presents: the live value on the opposite port (transparent path) or the stored copy (registered path). The two sections have fully separate controls. They can serve two unrelated 9-bit links, or the same controls can be fed to both to form one 18-bit path.

The block runs on one system clock `clk`. The capture controls `cap_ab` and `cap_ba` are strobes sampled on that clock. A register loads on the clock edge where its strobe is seen high after having been low. Capture happens whatever the enable and direction settings are. Each port is modelled as three vectors: an input, an output value and a per-bit output enable. A port's output value is zero whenever it is not enabled. Reset is synchronous and active high.

Top module: `xcvr_dual`

## Requirements
- R1: The sections are independent: controls of section k (data bits k*9 to k*9+8) affect only that section's outputs and registers.
- R2: While a section's `oe_n` is 1, its A and B output-enable bits are all 0 and its A and B output values are 0.
- R3: With `oe_n` 0, `dir` 1 makes the section drive B (all its `b_oe` bits 1, `a_oe` bits 0); `dir` 0 makes it drive A (all its `a_oe` bits 1, `b_oe` bits 0).
- R4: The A-side register loads the section's `a_in` at the clock edge where `cap_ab` is 1 and was 0 at the previous edge. A strobe held at 1 does not reload it. Otherwise the register holds its value.
- R5: The B-side register loads `b_in` under the same rule, using `cap_ba`.
- R6: Capture into both registers happens whatever the values of `oe_n` and `dir`, including while the section is isolated.
- R7: When driving B, `sel_ab` 0 gives `b_out` equal to the current `a_in` in the same cycle. `sel_ab` 1 gives the stored A-side register.
- R8: When driving A, `sel_ba` 0 gives `a_out` equal to the current `b_in`. `sel_ba` 1 gives the stored B-side register.
- R9: When both strobes rise at the same edge, both registers of the section load together, each from its own port.
- R10: While `rst` is 1, every output enable and output value is 0. A reset edge clears all registers to 0 and forgets any earlier strobe level.
- R11: On the registered path, the output does not follow the opposite input. It changes only in the cycle after a register load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 2 | Per-section output enable, active low |
| dir | input | 2 | Per-section direction, 1 = drive B from A side |
| cap_ab | input | 2 | Per-section A-side capture strobe |
| cap_ba | input | 2 | Per-section B-side capture strobe |
| sel_ab | input | 2 | Per-section B output source, 1 = stored |
| sel_ba | input | 2 | Per-section A output source, 1 = stored |
| a_in | input | 18 | Value seen on the A port |
| a_out | output | 18 | Value driven onto the A port |
| a_oe | output | 18 | Per-bit drive enable for the A port |
| b_in | input | 18 | Value seen on the B port |
| b_out | output | 18 | Value driven onto the B port |
| b_oe | output | 18 | Per-bit drive enable for the B port |

## Verification
The assertions assume that every input is settled before a clock edge and that the strobes are ordinary levels whose rises are to be counted once. The A and B inputs are taken as independent of the block's own outputs: no loop is closed around the transparent path. The stimulus changes every input only at the falling clock edge. It leaves both ports undriven by any external loop and toggles the strobes at random, including holds at 1 and simultaneous rises, so that each register-load rule is exercised.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int SEC_W = 9;
    localparam int N_SEC = 2;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drv_side_e;

    typedef struct packed {
        logic oe_n;
        logic to_b;
        logic cap_ab;
        logic cap_ba;
        logic st_ab;
        logic st_ba;
    } sec_ctrl_t;

    function automatic drv_side_e pick_side(input logic rst, input logic oe_n,
                                            input logic to_b);
        if (rst || oe_n) return DRV_NONE;
        return to_b ? DRV_B : DRV_A;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         load
);
    logic strobe_q;

    assign load = strobe && !strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            q        <= '0;
        end else begin
            strobe_q <= strobe;
            if (load) q <= d;
        end
    end

    // R4 / R5: a rising strobe captures the data
    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

    // R4 / R5: without a rise the value is held
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    // R4: a held-high strobe cannot load twice in a row
    assert_single_rise_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int W = SEC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  sec_ctrl_t    ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    logic [W-1:0] reg_a;
    logic [W-1:0] reg_b;
    logic         load_a;
    logic         load_b;
    drv_side_e    side;
    logic [W-1:0] src_to_b;
    logic [W-1:0] src_to_a;

    xcvr_store #(.W(W)) u_store_a (
        .clk(clk), .rst(rst), .strobe(ctrl.cap_ab),
        .d(a_in), .q(reg_a), .load(load_a)
    );

    xcvr_store #(.W(W)) u_store_b (
        .clk(clk), .rst(rst), .strobe(ctrl.cap_ba),
        .d(b_in), .q(reg_b), .load(load_b)
    );

    always_comb begin
        side     = pick_side(rst, ctrl.oe_n, ctrl.to_b);
        src_to_b = ctrl.st_ab ? reg_a : a_in;
        src_to_a = ctrl.st_ba ? reg_b : b_in;
        a_oe     = '0;
        b_oe     = '0;
        a_out    = '0;
        b_out    = '0;
        case (side)
            DRV_B: begin
                b_oe  = '1;
                b_out = src_to_b;
            end
            DRV_A: begin
                a_oe  = '1;
                a_out = src_to_a;
            end
            default: ;
        endcase
    end

    // R2: isolation drives neither port
    assert_isolate_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl.oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

    // R3: never both ports at once
    assert_one_side_R3: assert property (@(posedge clk) disable iff (rst)
        !((|a_oe) && (|b_oe)));

    // R7: transparent path follows the live input
    assert_live_ab_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.oe_n && ctrl.to_b && !ctrl.st_ab) |-> (b_out == a_in));

    // R8: registered path shows the stored copy
    assert_stored_ba_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.oe_n && !ctrl.to_b && ctrl.st_ba) |-> (a_out == reg_b));

    // R11: stored output stays put when no load happened
    assert_stored_steady_R11: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.oe_n && ctrl.to_b && ctrl.st_ab && !load_a) |=>
        ((!ctrl.oe_n && ctrl.to_b && ctrl.st_ab) -> $stable(b_out)));

endmodule

// File: rtl/xcvr_dual.sv
module xcvr_dual
    import xcvr_pkg::*;
#(
    parameter int W    = SEC_W,
    parameter int NSEC = N_SEC,
    localparam int TW  = W * NSEC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSEC-1:0] oe_n,
    input  logic [NSEC-1:0] dir,
    input  logic [NSEC-1:0] cap_ab,
    input  logic [NSEC-1:0] cap_ba,
    input  logic [NSEC-1:0] sel_ab,
    input  logic [NSEC-1:0] sel_ba,
    input  logic [TW-1:0]   a_in,
    output logic [TW-1:0]   a_out,
    output logic [TW-1:0]   a_oe,
    input  logic [TW-1:0]   b_in,
    output logic [TW-1:0]   b_out,
    output logic [TW-1:0]   b_oe
);
    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        sec_ctrl_t c;
        assign c.oe_n   = oe_n[s];
        assign c.to_b   = dir[s];
        assign c.cap_ab = cap_ab[s];
        assign c.cap_ba = cap_ba[s];
        assign c.st_ab  = sel_ab[s];
        assign c.st_ba  = sel_ba[s];

        xcvr_section #(.W(W)) u_sec (
            .clk  (clk),
            .rst  (rst),
            .ctrl (c),
            .a_in (a_in[s*W +: W]),
            .b_in (b_in[s*W +: W]),
            .a_out(a_out[s*W +: W]),
            .a_oe (a_oe[s*W +: W]),
            .b_out(b_out[s*W +: W]),
            .b_oe (b_oe[s*W +: W])
        );
    end

    // R10: nothing is driven while reset is held
    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |-> (a_oe == '0 && b_oe == '0));

endmodule

// File: tb/sim_xcvr_dual.sv
module sim_xcvr_dual;
    localparam int W  = 9;
    localparam int NS = 2;
    localparam int TW = W * NS;

    logic          clk = 1'b0;
    logic          rst;
    logic [NS-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
    logic [TW-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;

    logic [W-1:0]  mA[NS];
    logic [W-1:0]  mB[NS];
    logic          pAB[NS];
    logic          pBA[NS];

    int    n_chk = 0;
    int    n_bad = 0;
    string focus = "";
    bit    done  = 0;

    always #5 clk = ~clk;

    xcvr_dual u0 (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab),
        .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in),
        .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic string auto_tag(input int s);
        if (rst) return "R10";
        if (oe_n[s]) return "R2";
        if (dir[s]) return sel_ab[s] ? "R11" : "R7";
        return sel_ba[s] ? "R8" : "R3";
    endfunction

    function automatic logic [W-1:0] exp_bout(input int s);
        if (rst || oe_n[s] || !dir[s]) return '0;
        return sel_ab[s] ? mA[s] : a_in[s*W +: W];
    endfunction

    function automatic logic [W-1:0] exp_aout(input int s);
        if (rst || oe_n[s] || dir[s]) return '0;
        return sel_ba[s] ? mB[s] : b_in[s*W +: W];
    endfunction

    task automatic cycle();
        #2;
        for (int s = 0; s < NS; s++) begin
            string t;
            t = (focus != "") ? focus : auto_tag(s);
            chk(t, b_out[s*W +: W], exp_bout(s));
            chk(t, a_out[s*W +: W], exp_aout(s));
            chk(t, b_oe[s*W +: W], (!rst && !oe_n[s] && dir[s]) ? '1 : '0);
            chk(t, a_oe[s*W +: W], (!rst && !oe_n[s] && !dir[s]) ? '1 : '0);
        end
        @(posedge clk);
        for (int s = 0; s < NS; s++) begin
            if (rst) begin
                mA[s] = '0; mB[s] = '0; pAB[s] = 0; pBA[s] = 0;
            end else begin
                if (cap_ab[s] && !pAB[s]) mA[s] = a_in[s*W +: W];
                if (cap_ba[s] && !pBA[s]) mB[s] = b_in[s*W +: W];
                pAB[s] = cap_ab[s];
                pBA[s] = cap_ba[s];
            end
        end
        @(negedge clk);
    endtask

    task automatic show_a(input int s);
        oe_n[s] = 0; dir[s] = 1; sel_ab[s] = 1;
    endtask

    task automatic show_b(input int s);
        oe_n[s] = 0; dir[s] = 0; sel_ba[s] = 1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int s = 0; s < NS; s++) begin
            mA[s] = 'x; mB[s] = 'x; pAB[s] = 0; pBA[s] = 0;
        end
        rst = 1; oe_n = '0; dir = 2'b01; cap_ab = '0; cap_ba = '0;
        sel_ab = '1; sel_ba = '1; a_in = '1; b_in = '1;
        @(negedge clk);
        focus = "R10"; cycle(); cycle();
        rst = 0;
        // R10: registers read back zero after reset
        show_a(0); show_b(1); focus = "R10"; cycle();
        show_b(0); show_a(1); cycle();

        // R4: rise captures, held-high does not reload
        focus = "R4"; show_a(0); oe_n[1] = 1;
        a_in = {9'h0AA, 9'h155}; cap_ab[0] = 1; cycle();
        a_in = {9'h0AA, 9'h0F0}; cycle();
        a_in = {9'h0AA, 9'h00F}; cycle();
        cap_ab[0] = 0; cycle();

        // R6: capture while isolated, then R5 readback
        focus = "R6"; oe_n = '1; b_in = {9'h1C3, 9'h03C}; cap_ba = 2'b11; cycle();
        cap_ba = '0; b_in = '0; cycle();
        focus = "R5"; show_b(0); show_b(1); cycle();

        // R9: both strobes rise together
        focus = "R9"; oe_n = '1; a_in = {9'h111, 9'h1EE}; b_in = {9'h022, 9'h1DD};
        cap_ab[0] = 1; cap_ba[0] = 1; cycle();
        cap_ab = '0; cap_ba = '0; a_in = '0; b_in = '0;
        show_a(0); cycle(); show_b(0); cycle();

        // R1: section 1 strobes leave section 0 untouched
        focus = "R1"; oe_n = '1; a_in = '1; cap_ab = 2'b10; cycle();
        cap_ab = '0; show_a(0); show_a(1); cycle();

        // R11: stored output ignores live input changes
        focus = "R11"; a_in = {9'h0, 9'h1A5}; cycle(); a_in = 18'h2AAAA; cycle();

        // Random mix
        focus = "";
        for (int i = 0; i < 600; i++) begin
            oe_n   = NS'($urandom_range(0, 3));
            dir    = NS'($urandom());
            sel_ab = NS'($urandom());
            sel_ba = NS'($urandom());
            if ($urandom_range(0, 2) == 0) cap_ab = NS'($urandom());
            if ($urandom_range(0, 2) == 0) cap_ba = NS'($urandom());
            a_in   = TW'($urandom());
            b_in   = TW'($urandom());
            rst    = ($urandom_range(0, 199) == 0);
            cycle();
        end
        rst = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule